// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by reading a two-level translation table from memory. A level-1 entry maps a whole 1 MiB region directly (a section) or points to a level-2 table. A level-2 entry maps a 64 KiB large page or a 4 KiB small page. Any other encoding ends the walk with a page fault. A mode input selects narrow entries, whose physical address is 32 bits, or wide entries. Wide entries are shifted left by four bits to reach a 36-bit physical space. In wide mode the table base register holds a 4 KiB frame number, not a byte address.

A client offers one translation at a time with a valid/ready handshake. The walker sends its table reads through a single-outstanding read port: an address with valid/ready, then one data beat marked by a response valid. The walk ends with a one-cycle completion pulse. This pulse carries the physical address, or a read-side or write-side fault flag that follows the direction of the request. It also carries the virtual address that was walked.

The controller is an enumerated state machine with six states.

| State | Meaning | Next state |
|---|---|---|
| ST_IDLE | Waiting for a request | ST_L1_REQ when a request is accepted |
| ST_L1_REQ | Presents the level-1 read | ST_L1_WAIT when `mem_req_ready` is high |
| ST_L1_WAIT | Waits for the level-1 entry | ST_L2_REQ on a table pointer, ST_DONE on a section or a fault |
| ST_L2_REQ | Presents the level-2 read | ST_L2_WAIT when `mem_req_ready` is high |
| ST_L2_WAIT | Waits for the level-2 entry | ST_DONE when the response arrives |
| ST_DONE | Raises the completion pulse | ST_IDLE |

Top module: `iova_walker`

## Requirements
- R1: After reset, req_ready is 1, and done_valid and mem_req_valid are 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. From the next cycle, req_ready stays 0 until the cycle after the done pulse, so only one walk is in flight.
- R3: The first read goes to the level-1 base plus 4 times VA[31:20]. In narrow mode (pa36_mode=0) the level-1 base is tbl_base. In wide mode (pa36_mode=1) it is tbl_base shifted left by 12 and truncated to 36 bits.
- R4: A level-1 entry with bits[1:0]=2'b10 completes the walk with no second read. PA = (entry shifted) with bits[19:0] cleared, plus VA[19:0].
- R5: A level-1 entry with bits[1:0]=2'b01 causes a second read at ((entry with bits[5:0] cleared) shifted) + 4 times VA[19:12].
- R6: A level-1 entry with bits[1:0] equal to 2'b00 or 2'b11 ends the walk as a fault, with no second read.
- R7: A level-2 entry with bit 1 set (2'b10 or 2'b11) gives PA = (entry shifted) with bits[11:0] cleared, plus VA[11:0].
- R8: A level-2 entry with bits[1:0]=2'b01 gives PA = (entry shifted) with bits[15:0] cleared, plus VA[15:0].
- R9: A level-2 entry with bits[1:0]=2'b00 ends the walk as a fault.
- R10: "Shifted" means zero-extended to 36 bits and shifted left by 0 in narrow mode or by 4 in wide mode.
- R11: On a fault, done_fault_rd is 1 for a read request (req_write=0) and done_fault_wr is 1 for a write request. The two flags are never both 1, and done_pa is 0. On every completion, done_va equals the request's VA.
- R12: mem_req_valid holds with a stable mem_req_addr until mem_req_ready. After a read is accepted, no new read is issued until its response has returned.
- R13: done_valid is high for exactly one cycle per walk, and req_ready is 1 in the following cycle.
- R14: tbl_base and pa36_mode are captured when the request is accepted. Changing them during a walk has no effect on its addresses or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| tbl_base | input | 32 | Level-1 table base (byte address or frame number) |
| pa36_mode | input | 1 | 1 selects wide entries and a frame-number base |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 36 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_pa | output | 36 | Translated physical address (0 on fault) |
| done_va | output | 32 | Virtual address of the completed walk |
| done_fault_rd | output | 1 | Page fault on a read request |
| done_fault_wr | output | 1 | Page fault on a write request |

## Verification
The bench covers each entry encoding at both levels, including the 2'b11 level-1 code and the 2'b11 level-2 code. A decoder that treated 2'b11 as a section, or tested both low bits of a level-2 small-page entry, would return a physical address instead of a fault, or the reverse. Walks in wide mode check that the entry shift is applied both to leaf addresses and to the level-2 table pointer, and that the frame-number base is scaled. A walker that shifted only one of these would read the wrong address. One walk changes the base and mode inputs just after acceptance. An all-ones address walk checks that the offset bits are carried through. A design that sampled these inputs late, or truncated the offset bits, would produce a different read address or result. Read requests are stalled to show that the address is held. The bench also confirms that no second read is issued during a wait, or after a section or a level-1 fault.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        PTE_FAULT,
        PTE_LEAF,
        PTE_NEXT
    } pte_kind_t;

endpackage

// File: rtl/pte_decode.sv
module pte_decode
    import ptw_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 36,
    parameter int PTE_W       = 32,
    parameter int L1_IDX_W    = 12,
    parameter int L2_IDX_W    = 8,
    parameter int LPAGE_OFS_W = 16,
    parameter int ENT_SHIFT   = 4,
    parameter int PFN_SHIFT   = 12,
    parameter int TBL_ALIGN_W = 6
) (
    input  logic [VA_W-1:0]  va,
    input  logic [VA_W-1:0]  base,
    input  logic             wide,
    input  logic             level2,
    input  logic [PTE_W-1:0] entry,
    output pte_kind_t        kind,
    output logic [PA_W-1:0]  leaf_pa,
    output logic [PA_W-1:0]  l1_addr,
    output logic [PA_W-1:0]  l2_addr
);
    localparam int SECT_OFS_W = VA_W - L1_IDX_W;
    localparam int PAGE_OFS_W = SECT_OFS_W - L2_IDX_W;
    localparam logic [PA_W-1:0] ONES      = {PA_W{1'b1}};
    localparam logic [PA_W-1:0] SECT_KEEP = ONES << SECT_OFS_W;
    localparam logic [PA_W-1:0] LPG_KEEP  = ONES << LPAGE_OFS_W;
    localparam logic [PA_W-1:0] SPG_KEEP  = ONES << PAGE_OFS_W;

    logic [PA_W-1:0] ent_ext;
    logic [PA_W-1:0] ent_sh;
    logic [PA_W-1:0] tbl_ext;
    logic [PA_W-1:0] tbl_sh;
    logic [PA_W-1:0] base_byte;
    logic [PA_W-1:0] va_ext;

    assign va_ext    = PA_W'(va);
    assign ent_ext   = PA_W'(entry);
    assign ent_sh    = wide ? (ent_ext << ENT_SHIFT) : ent_ext;
    assign tbl_ext   = PA_W'({entry[PTE_W-1:TBL_ALIGN_W], {TBL_ALIGN_W{1'b0}}});
    assign tbl_sh    = wide ? (tbl_ext << ENT_SHIFT) : tbl_ext;
    assign base_byte = wide ? PA_W'({base, {PFN_SHIFT{1'b0}}}) : PA_W'(base);

    assign l1_addr = base_byte + PA_W'({va[VA_W-1:SECT_OFS_W], 2'b00});
    assign l2_addr = tbl_sh + PA_W'({va[SECT_OFS_W-1:PAGE_OFS_W], 2'b00});

    always_comb begin
        kind    = PTE_FAULT;
        leaf_pa = '0;
        if (!level2) begin
            unique case (entry[1:0])
                2'b10: begin
                    kind    = PTE_LEAF;
                    leaf_pa = (ent_sh & SECT_KEEP) | (va_ext & ~SECT_KEEP);
                end
                2'b01:   kind = PTE_NEXT;
                default: kind = PTE_FAULT;
            endcase
        end else begin
            unique case (entry[1:0])
                2'b10, 2'b11: begin
                    kind    = PTE_LEAF;
                    leaf_pa = (ent_sh & SPG_KEEP) | (va_ext & ~SPG_KEEP);
                end
                2'b01: begin
                    kind    = PTE_LEAF;
                    leaf_pa = (ent_sh & LPG_KEEP) | (va_ext & ~LPG_KEEP);
                end
                default: kind = PTE_FAULT;
            endcase
        end
    end

    always_comb begin
        if (level2) begin
            AST_L2_NEVER_NEXT: assert (kind != PTE_NEXT); // R9
        end
    end

endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
    import ptw_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 36,
    parameter int PAGE_OFS_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    input  logic            req_write,
    input  logic [VA_W-1:0] tbl_base,
    input  logic            pa36_mode,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    output logic            done_valid,
    output logic [PA_W-1:0] done_pa,
    output logic [VA_W-1:0] done_va,
    output logic            done_fault_rd,
    output logic            done_fault_wr,
    output logic [VA_W-1:0] cur_va,
    output logic [VA_W-1:0] cur_base,
    output logic            cur_wide,
    output logic            level2,
    input  pte_kind_t       dec_kind,
    input  logic [PA_W-1:0] dec_leaf_pa,
    input  logic [PA_W-1:0] dec_l1_addr,
    input  logic [PA_W-1:0] dec_l2_addr
);
    walk_state_t state_q, state_d;
    logic [VA_W-1:0] va_q, base_q;
    logic            wr_q, wide_q, flt_q;
    logic [PA_W-1:0] pa_q, nxt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)     state_d = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid)
                            state_d = (dec_kind == PTE_NEXT) ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  if (mem_req_ready) state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            base_q <= '0;
            wr_q   <= 1'b0;
            wide_q <= 1'b0;
            flt_q  <= 1'b0;
            pa_q   <= '0;
            nxt_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q   <= req_va;
                base_q <= tbl_base;
                wr_q   <= req_write;
                wide_q <= pa36_mode;
            end
            if (state_q == ST_L1_WAIT && mem_rsp_valid) begin
                nxt_q <= dec_l2_addr;
                pa_q  <= (dec_kind == PTE_LEAF) ? dec_leaf_pa : '0;
                flt_q <= (dec_kind == PTE_FAULT);
            end
            if (state_q == ST_L2_WAIT && mem_rsp_valid) begin
                pa_q  <= (dec_kind == PTE_LEAF) ? dec_leaf_pa : '0;
                flt_q <= (dec_kind != PTE_LEAF);
            end
        end
    end

    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        mem_req_addr  = (state_q == ST_L2_REQ) ? nxt_q : dec_l1_addr;
        done_valid    = (state_q == ST_DONE);
        done_pa       = pa_q;
        done_va       = va_q;
        done_fault_rd = (state_q == ST_DONE) && flt_q && !wr_q;
        done_fault_wr = (state_q == ST_DONE) && flt_q && wr_q;
        cur_va        = va_q;
        cur_base      = base_q;
        cur_wide      = wide_q;
        level2        = (state_q == ST_L2_WAIT);
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R13
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready); // R13
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R2
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R12
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid); // R12
    AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_fault_rd, done_fault_wr})); // R11
    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_fault_rd && !done_fault_wr
        |-> done_pa[PAGE_OFS_W-1:0] == done_va[PAGE_OFS_W-1:0]); // R7

endmodule

// File: rtl/iova_walker.sv
module iova_walker
    import ptw_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 36,
    parameter int PTE_W       = 32,
    parameter int L1_IDX_W    = 12,
    parameter int L2_IDX_W    = 8,
    parameter int LPAGE_OFS_W = 16,
    parameter int ENT_SHIFT   = 4,
    parameter int PFN_SHIFT   = 12,
    parameter int TBL_ALIGN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic [VA_W-1:0]  tbl_base,
    input  logic             pa36_mode,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done_valid,
    output logic [PA_W-1:0]  done_pa,
    output logic [VA_W-1:0]  done_va,
    output logic             done_fault_rd,
    output logic             done_fault_wr
);
    localparam int PAGE_OFS_W = VA_W - L1_IDX_W - L2_IDX_W;

    logic [VA_W-1:0] cur_va, cur_base;
    logic            cur_wide, level2;
    pte_kind_t       dec_kind;
    logic [PA_W-1:0] dec_leaf_pa, dec_l1_addr, dec_l2_addr;

    walk_fsm #(
        .VA_W       (VA_W),
        .PA_W       (PA_W),
        .PAGE_OFS_W (PAGE_OFS_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_write     (req_write),
        .tbl_base      (tbl_base),
        .pa36_mode     (pa36_mode),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .done_valid    (done_valid),
        .done_pa       (done_pa),
        .done_va       (done_va),
        .done_fault_rd (done_fault_rd),
        .done_fault_wr (done_fault_wr),
        .cur_va        (cur_va),
        .cur_base      (cur_base),
        .cur_wide      (cur_wide),
        .level2        (level2),
        .dec_kind      (dec_kind),
        .dec_leaf_pa   (dec_leaf_pa),
        .dec_l1_addr   (dec_l1_addr),
        .dec_l2_addr   (dec_l2_addr)
    );

    pte_decode #(
        .VA_W        (VA_W),
        .PA_W        (PA_W),
        .PTE_W       (PTE_W),
        .L1_IDX_W    (L1_IDX_W),
        .L2_IDX_W    (L2_IDX_W),
        .LPAGE_OFS_W (LPAGE_OFS_W),
        .ENT_SHIFT   (ENT_SHIFT),
        .PFN_SHIFT   (PFN_SHIFT),
        .TBL_ALIGN_W (TBL_ALIGN_W)
    ) u_dec (
        .va      (cur_va),
        .base    (cur_base),
        .wide    (cur_wide),
        .level2  (level2),
        .entry   (mem_rsp_data),
        .kind    (dec_kind),
        .leaf_pa (dec_leaf_pa),
        .l1_addr (dec_l1_addr),
        .l2_addr (dec_l2_addr)
    );

endmodule

// File: tb/iova_walker_bench.sv
`timescale 1ns/1ps
module iova_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic [31:0] tbl_base = '0;
    logic        pa36_mode = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [35:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [35:0] done_pa;
    logic [31:0] done_va;
    logic        done_fault_rd;
    logic        done_fault_wr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    iova_walker u_iova_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_write     (req_write),
        .tbl_base      (tbl_base),
        .pa36_mode     (pa36_mode),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done_valid    (done_valid),
        .done_pa       (done_pa),
        .done_va       (done_va),
        .done_fault_rd (done_fault_rd),
        .done_fault_wr (done_fault_wr)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One complete walk with a responding memory model; every table read is
    // stalled for one cycle before acceptance.
    task automatic run_walk(input string tag, input logic [31:0] va, input logic wr,
                            input logic wide, input logic [31:0] base,
                            input logic [31:0] e1, input logic [31:0] e2,
                            input logic [35:0] a1, input logic [35:0] a2,
                            input int nreads, input logic fault,
                            input logic [35:0] pa, input logic flip);
        int  rd = 0;
        bit  got = 0;
        bit  busy_bad = 0;
        logic [35:0] held;
        @(negedge clk);
        tbl_base = base; pa36_mode = wide; req_va = va; req_write = wr; req_valid = 1'b1;
        chk(tag, "ready before accept (R2)", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) begin
            pa36_mode = ~wide;   // R14: must not affect the walk
            tbl_base  = ~base;
        end
        for (int cyc = 0; cyc < 100 && !got; cyc++) begin
            if (done_valid) begin
                got = 1;
                chk(tag, "read count", 64'(rd), 64'(nreads));
                chk(tag, "done_va (R11)", 64'(done_va), 64'(va));
                chk(tag, "fault_rd (R11)", 64'(done_fault_rd), 64'(fault && !wr));
                chk(tag, "fault_wr (R11)", 64'(done_fault_wr), 64'(fault && wr));
                chk(tag, "pa", 64'(done_pa), fault ? 64'd0 : 64'(pa));
                chk(tag, "busy while walking (R2)", 64'(busy_bad), 64'd0);
                @(negedge clk);
                chk(tag, "single done pulse (R13)", 64'(done_valid), 64'd0);
                chk(tag, "ready after done (R13)", 64'(req_ready), 64'd1);
            end else if (mem_req_valid) begin
                if (req_ready) busy_bad = 1;
                held = mem_req_addr;
                chk(tag, (rd == 0) ? "level-1 address (R3)" : "level-2 address (R5)",
                    64'(held), (rd == 0) ? 64'(a1) : 64'(a2));
                @(negedge clk);
                chk(tag, "request held (R12)", {27'd0, mem_req_valid, held},
                    {27'd0, 1'b1, mem_req_addr});
                mem_req_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                mem_req_ready = 1'b0;
                chk(tag, "no reissue while waiting (R12)", 64'(mem_req_valid), 64'd0);
                if (req_ready) busy_bad = 1;
                mem_rsp_data  = (rd == 0) ? e1 : e2;
                mem_rsp_valid = 1'b1;
                @(posedge clk);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                rd++;
            end else begin
                if (req_ready) busy_bad = 1;
                @(negedge clk);
            end
        end
        chk(tag, "walk completed", 64'(got), 64'd1);
        pa36_mode = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "done_valid", 64'(done_valid), 64'd0);
        chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_section_narrow;  // R4 R3
        run_walk("R4", 32'h1234_5678, 1'b0, 1'b0, 32'h0004_0000, 32'h8760_0002, 32'h0,
                 36'h0_0004_048C, 36'h0, 1, 1'b0, 36'h0_8764_5678, 1'b0);
    endtask

    task automatic t_section_top_va;  // R4 boundary: last level-1 index
        run_walk("R4", 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0000_0000, 32'hFFF0_0002, 32'h0,
                 36'h0_0000_3FFC, 36'h0, 1, 1'b0, 36'h0_FFFF_FFFF, 1'b0);
    endtask

    task automatic t_small_narrow;    // R5 R7
        run_walk("R7", 32'h0ABC_D123, 1'b0, 1'b0, 32'h0010_0000, 32'h0022_3401, 32'h5555_6002,
                 36'h0_0010_02AC, 36'h0_0022_3734, 2, 1'b0, 36'h0_5555_6123, 1'b0);
        run_walk("R7", 32'h0ABC_D123, 1'b1, 1'b0, 32'h0010_0000, 32'h0022_3401, 32'h5555_6003,
                 36'h0_0010_02AC, 36'h0_0022_3734, 2, 1'b0, 36'h0_5555_6123, 1'b0);
    endtask

    task automatic t_large_narrow;    // R8
        run_walk("R8", 32'h0ABC_D123, 1'b0, 1'b0, 32'h0010_0000, 32'h0022_3401, 32'h7777_0001,
                 36'h0_0010_02AC, 36'h0_0022_3734, 2, 1'b0, 36'h0_7777_D123, 1'b0);
    endtask

    task automatic t_l1_faults;       // R6 R11
        run_walk("R6", 32'h0123_4567, 1'b0, 1'b0, 32'h0000_8000, 32'h1234_5600, 32'h0,
                 36'h0_0000_8048, 36'h0, 1, 1'b1, 36'h0, 1'b0);
        run_walk("R6", 32'h0123_4567, 1'b1, 1'b0, 32'h0000_8000, 32'h1234_5603, 32'h0,
                 36'h0_0000_8048, 36'h0, 1, 1'b1, 36'h0, 1'b0);
    endtask

    task automatic t_l2_fault;        // R9 R11
        run_walk("R9", 32'h0ABC_D123, 1'b1, 1'b0, 32'h0010_0000, 32'h0022_3401, 32'hFFFF_FFFC,
                 36'h0_0010_02AC, 36'h0_0022_3734, 2, 1'b1, 36'h0, 1'b0);
    endtask

    task automatic t_wide_section;    // R10 R3
        run_walk("R10", 32'h0030_0ABC, 1'b0, 1'b1, 32'h0000_0012, 32'h9000_0002, 32'h0,
                 36'h0_0001_200C, 36'h0, 1, 1'b0, 36'h9_0000_0ABC, 1'b0);
    endtask

    task automatic t_wide_small;      // R10 R5
        run_walk("R10", 32'h0051_2345, 1'b0, 1'b1, 32'h0000_0034, 32'h0001_2341, 32'hABCD_E002,
                 36'h0_0003_4014, 36'h0_0012_3448, 2, 1'b0, 36'hA_BCDE_0345, 1'b0);
    endtask

    task automatic t_inputs_captured; // R14
        run_walk("R14", 32'h0ABC_D123, 1'b0, 1'b0, 32'h0010_0000, 32'h0022_3401, 32'h7777_0001,
                 36'h0_0010_02AC, 36'h0_0022_3734, 2, 1'b0, 36'h0_7777_D123, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_section_narrow();
        t_section_top_va();
        t_small_narrow();
        t_large_narrow();
        t_l1_faults();
        t_l2_fault();
        t_wide_section();
        t_wide_small();
        t_inputs_captured();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule